// File: doc/BRIEF.md
# Serial Configuration Register Loader

This block sits on the CPU write path of a cartridge banking controller. A CPU store to any address in the upper half of the 64 KiB space carries one payload bit on data line 0. Five accepted stores assemble a 5-bit word, least significant bit first. The address of the fifth store selects one of four configuration registers, and the word is written into it. The registers are held here and driven to the bank decoders, which are not part of this block.

A store with data line 7 high is a reset command. It throws away any partly assembled word and sets the two mode bits (mask 0x0C) of configuration register 0. The other bits of that register stay as they were. Some instructions read, modify and write back, so they issue two stores one after the other. To cope with that, a saturating count of CPU cycle ticks is kept from the last accepted reset. Any store that arrives before two ticks have passed is dropped.

Each completed load raises a one-cycle strobe for the register that was written. It also raises refresh pulses that tell the downstream decoders which of their outputs must be recomputed. A reset command has its own one-cycle pulse.

Top module: `ser_cfg_loader`

## Requirements
- R1: After reset, cfg0 reads 0x1F and cfg1, cfg2 and cfg3 read 0x00. All strobes and pulses are low, and the first accepted store lands in bit 0.
- R2: A store with address bit 15 low has no effect on the fill level or the registers.
- R3: Accepted payload bits fill the word least significant first. The first bit lands in bit 0 and each later bit lands one position higher.
- R4: On the fifth accepted payload store, the word is written into the register selected by address bits 14:13 of that store (00=cfg0 … 11=cfg3). The fill level then returns to zero. No other register changes.
- R5: In the cycle after the edge that captures the fifth store, upd_strobe has exactly bit n high, where n is the target register. It is high for one cycle.
- R6: The refresh pulses come together with upd_strobe. Target 0 raises mirror, chr and prg. Target 1 raises chr and prg. Target 2 raises chr only. Target 3 raises prg only.
- R7: An accepted store with data bit 7 high does three things. It discards the partial word and ORs 0x0C into cfg0, leaving its other bits unchanged. It leaves cfg1 to cfg3 unchanged. In the next cycle it raises cmd_reset and refresh_prg for one cycle.
- R8: A store is ignored if it arrives when fewer than 2 cpu_tick cycles have passed since the last accepted reset command. This applies to both payload stores and reset commands. A store that arrives after 2 ticks is accepted.
- R9: The tick count since a reset saturates. After any number of ticks of 2 or more, stores are still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_tick | input | 1 | One pulse per CPU cycle |
| wr_en | input | 1 | CPU write strobe, one clock per store |
| wr_addr | input | 16 | CPU write address |
| wr_d7 | input | 1 | Data bit 7 (reset command) |
| wr_d0 | input | 1 | Data bit 0 (payload bit) |
| cfg0 | output | 5 | Configuration register 0 (control) |
| cfg1 | output | 5 | Configuration register 1 |
| cfg2 | output | 5 | Configuration register 2 |
| cfg3 | output | 5 | Configuration register 3 |
| upd_strobe | output | 4 | One-hot register update pulse |
| refresh_mirror | output | 1 | Mirroring must be recomputed |
| refresh_chr | output | 1 | Pattern banking must be recomputed |
| refresh_prg | output | 1 | Program banking must be recomputed |
| cmd_reset | output | 1 | One-cycle pulse on an accepted reset command |

## Verification
The hardest situation to reach is a store that lands inside the two-tick guard window right after a reset command, while a partial word is pending. The bench first leaves three payload bits buffered. It then issues a reset and sends stores at zero and one tick after it, followed by one at two ticks. The final register value shows which of those stores were counted. A separate run waits five ticks before a second reset command, so a count that wrapped instead of saturating would drop that command.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;

  localparam int CFG_W    = 5;
  localparam int CFG_N    = 4;
  localparam int IDX_W    = $clog2(CFG_N);
  localparam logic [CFG_W-1:0] CFG0_INIT = 5'h1F;
  localparam logic [CFG_W-1:0] MODE_MASK = 5'h0C;

  typedef logic [CFG_W-1:0] cfg_t;

  typedef struct packed {
    logic mir;
    logic chr;
    logic prg;
  } refresh_t;

  // which downstream decoders depend on a given register
  function automatic refresh_t refresh_for(input logic [IDX_W-1:0] idx);
    refresh_t r;
    r.mir = (idx == 2'd0);
    r.chr = (idx != 2'd3);
    r.prg = (idx != 2'd2);
    return r;
  endfunction

  function automatic cfg_t force_mode(input cfg_t v);
    return v | MODE_MASK;
  endfunction

  function automatic cfg_t place_bit(input cfg_t word, input int unsigned pos, input logic b);
    cfg_t w;
    w = word;
    w[pos] = b;
    return w;
  endfunction

endpackage

// File: rtl/sercfg_guard.sv
module sercfg_guard #(
  parameter int GUARD_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic restart,
  output logic open_o
);
  localparam int CW = $clog2(GUARD_CYC + 1);
  localparam logic [CW-1:0] SAT = CW'(GUARD_CYC);

  logic [CW-1:0] since_q;

  assign open_o = (since_q >= SAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      since_q <= SAT;
    else if (restart)
      since_q <= '0;
    else if (tick && (since_q < SAT))
      since_q <= since_q + 1'b1;
  end
endmodule

// File: rtl/sercfg_shift.sv
module sercfg_shift
  import sercfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic       clear,
  input  logic       bit_in,
  output logic       commit_o,
  output cfg_t       word_o,
  output logic [$clog2(CFG_W+1)-1:0] fill_o
);
  localparam int FW = $clog2(CFG_W + 1);
  localparam logic [FW-1:0] LAST = FW'(CFG_W - 1);

  cfg_t          word_q;
  logic [FW-1:0] fill_q;
  cfg_t          word_nxt;

  assign word_nxt = place_bit(word_q, int'(fill_q), bit_in);
  assign commit_o = push && (fill_q == LAST);
  assign word_o   = word_nxt;
  assign fill_o   = fill_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      fill_q <= '0;
    end else if (clear || commit_o) begin
      word_q <= '0;
      fill_q <= '0;
    end else if (push) begin
      word_q <= word_nxt;
      fill_q <= fill_q + 1'b1;
    end
  end
endmodule

// File: rtl/sercfg_regs.sv
module sercfg_regs
  import sercfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [IDX_W-1:0] target,
  input  cfg_t             word,
  input  logic             mode_reset,
  output cfg_t             cfg_o [CFG_N],
  output logic [CFG_N-1:0] upd_o,
  output refresh_t         refresh_o,
  output logic             reset_pulse_o
);
  genvar gi;
  generate
    for (gi = 0; gi < CFG_N; gi++) begin : g_reg
      localparam cfg_t INIT = (gi == 0) ? CFG0_INIT : '0;
      cfg_t r_q;
      logic hit;
      assign hit = commit && (target == IDX_W'(gi));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          r_q <= INIT;
        else if (hit)
          r_q <= word;
        else if ((gi == 0) && mode_reset)
          r_q <= force_mode(r_q);
      end
      assign cfg_o[gi] = r_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) upd_o[gi] <= 1'b0;
        else        upd_o[gi] <= hit;
      end
    end
  endgenerate

  refresh_t ref_nxt;
  always_comb begin
    ref_nxt = '0;
    if (commit) ref_nxt = refresh_for(target);
    if (mode_reset) ref_nxt.prg = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      refresh_o     <= '0;
      reset_pulse_o <= 1'b0;
    end else begin
      refresh_o     <= ref_nxt;
      reset_pulse_o <= mode_reset;
    end
  end
endmodule

// File: rtl/ser_cfg_loader.sv
module ser_cfg_loader
  import sercfg_pkg::*;
#(
  parameter int GUARD_CYC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_tick,
  input  logic        wr_en,
  input  logic [15:0] wr_addr,
  input  logic        wr_d7,
  input  logic        wr_d0,
  output logic [4:0]  cfg0,
  output logic [4:0]  cfg1,
  output logic [4:0]  cfg2,
  output logic [4:0]  cfg3,
  output logic [3:0]  upd_strobe,
  output logic        refresh_mirror,
  output logic        refresh_chr,
  output logic        refresh_prg,
  output logic        cmd_reset
);
  // named internal events
  logic             in_window;
  logic             guard_open;
  logic             acc;
  logic             acc_reset;
  logic             acc_bit;
  logic             commit;
  cfg_t             word;
  logic [IDX_W-1:0] target;
  logic [$clog2(CFG_W+1)-1:0] fill_level;
  cfg_t             regs [CFG_N];
  refresh_t         refresh;

  assign in_window = wr_en && wr_addr[15];
  assign acc       = in_window && guard_open;
  assign acc_reset = acc && wr_d7;
  assign acc_bit   = acc && !wr_d7;
  assign target    = wr_addr[14:13];

  sercfg_guard #(.GUARD_CYC(GUARD_CYC)) u_guard (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (cpu_tick),
    .restart (acc_reset),
    .open_o  (guard_open)
  );

  sercfg_shift u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (acc_bit),
    .clear    (acc_reset),
    .bit_in   (wr_d0),
    .commit_o (commit),
    .word_o   (word),
    .fill_o   (fill_level)
  );

  sercfg_regs u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .commit        (commit),
    .target        (target),
    .word          (word),
    .mode_reset    (acc_reset),
    .cfg_o         (regs),
    .upd_o         (upd_strobe),
    .refresh_o     (refresh),
    .reset_pulse_o (cmd_reset)
  );

  assign cfg0           = regs[0];
  assign cfg1           = regs[1];
  assign cfg2           = regs[2];
  assign cfg3           = regs[3];
  assign refresh_mirror = refresh.mir;
  assign refresh_chr    = refresh.chr;
  assign refresh_prg    = refresh.prg;
endmodule

// File: rtl/sercfg_checker.sv
module sercfg_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [15:0] wr_addr,
  input logic        guard_open,
  input logic        acc,
  input logic        acc_reset,
  input logic        commit,
  input logic [2:0]  fill_level,
  input logic [4:0]  cfg0,
  input logic [4:0]  cfg1,
  input logic [4:0]  cfg2,
  input logic [4:0]  cfg3,
  input logic [3:0]  upd_strobe,
  input logic        refresh_mirror,
  input logic        refresh_chr,
  input logic        refresh_prg,
  input logic        cmd_reset
);
  assert_low_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_addr[15]) |-> !acc);

  assert_fill_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level < 3'd5);

  assert_commit_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (upd_strobe != 4'd0));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && !acc_reset) |=> ($stable(cfg0) && $stable(cfg1) && $stable(cfg2) && $stable(cfg3)));

  assert_onehot_update_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(upd_strobe));

  assert_refresh_tgt3_R6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_strobe[3] |-> (refresh_prg && !refresh_chr && !refresh_mirror));

  assert_mode_force_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_reset |=> (cmd_reset && refresh_prg && (cfg0[3:2] == 2'b11) && (upd_strobe == 4'd0)));

  assert_guard_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !guard_open) |=> ((upd_strobe == 4'd0) && !cmd_reset));
endmodule

bind ser_cfg_loader sercfg_checker u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .wr_en          (wr_en),
  .wr_addr        (wr_addr),
  .guard_open     (guard_open),
  .acc            (acc),
  .acc_reset      (acc_reset),
  .commit         (commit),
  .fill_level     (fill_level),
  .cfg0           (cfg0),
  .cfg1           (cfg1),
  .cfg2           (cfg2),
  .cfg3           (cfg3),
  .upd_strobe     (upd_strobe),
  .refresh_mirror (refresh_mirror),
  .refresh_chr    (refresh_chr),
  .refresh_prg    (refresh_prg),
  .cmd_reset      (cmd_reset)
);

// File: tb/sim_ser_cfg_loader.sv
`timescale 1ns/1ps
module sim_ser_cfg_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = 16'h0;
  logic        wr_d7 = 1'b0;
  logic        wr_d0 = 1'b0;
  logic [4:0]  cfg0, cfg1, cfg2, cfg3;
  logic [3:0]  upd_strobe;
  logic        refresh_mirror, refresh_chr, refresh_prg, cmd_reset;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // values captured right after the edge of the last store
  logic [3:0] s_upd;
  logic [2:0] s_ref;
  logic       s_rst;

  logic [4:0] model [4];

  always #4 clk = ~clk;

  ser_cfg_loader u0 (
    .clk(clk), .rst_n(rst_n), .cpu_tick(cpu_tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_d7(wr_d7), .wr_d0(wr_d0), .cfg0(cfg0), .cfg1(cfg1), .cfg2(cfg2), .cfg3(cfg3),
    .upd_strobe(upd_strobe), .refresh_mirror(refresh_mirror), .refresh_chr(refresh_chr),
    .refresh_prg(refresh_prg), .cmd_reset(cmd_reset)
  );

  // {target[1:0], value[4:0], expected refresh {mir,chr,prg}}
  localparam logic [9:0] VEC [8] = '{
    {2'd1, 5'h16, 3'b011},
    {2'd2, 5'h0B, 3'b010},
    {2'd3, 5'h01, 3'b001},
    {2'd0, 5'h12, 3'b111},
    {2'd3, 5'h1E, 3'b001},
    {2'd1, 5'h09, 3'b011},
    {2'd2, 5'h10, 3'b010},
    {2'd0, 5'h07, 3'b111}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cpu_tick = 1'b1;
      @(negedge clk); cpu_tick = 1'b0;
    end
  endtask

  task automatic store(input logic [15:0] a, input logic d7, input logic d0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_d7 = d7; wr_d0 = d0;
    @(posedge clk); #1;
    s_upd = upd_strobe;
    s_ref = {refresh_mirror, refresh_chr, refresh_prg};
    s_rst = cmd_reset;
    @(negedge clk);
    wr_en = 1'b0; wr_d7 = 1'b0; wr_d0 = 1'b0;
  endtask

  function automatic logic [15:0] addr_of(input logic [1:0] idx);
    return 16'h8000 + (16'(idx) * 16'h2000) + 16'h0123;
  endfunction

  task automatic load(input logic [1:0] idx, input logic [4:0] v);
    for (int b = 0; b < 5; b++) store(addr_of(idx), 1'b0, v[b]);
  endtask

  task automatic cmp_regs(input string req);
    chk(req, {27'd0, cfg0}, {27'd0, model[0]});
    chk(req, {27'd0, cfg1}, {27'd0, model[1]});
    chk(req, {27'd0, cfg2}, {27'd0, model[2]});
    chk(req, {27'd0, cfg3}, {27'd0, model[3]});
  endtask

  initial begin
    #1500000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model[0] = 5'h1F; model[1] = 5'h00; model[2] = 5'h00; model[3] = 5'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    cmp_regs("R1");
    chk("R1 strobes", {24'd0, upd_strobe, refresh_mirror, refresh_chr, refresh_prg, cmd_reset}, 32'd0);

    // table: R3 bit order, R4 target, R5 strobe, R6 refresh
    for (int k = 0; k < 8; k++) begin
      logic [1:0] ix;
      logic [4:0] val;
      ix = VEC[k][9:8]; val = VEC[k][7:3];
      load(ix, val);
      model[ix] = val;
      chk("R5 strobe", {28'd0, s_upd}, {28'd0, 4'b0001 << ix});
      chk("R6 refresh", {29'd0, s_ref}, {29'd0, VEC[k][2:0]});
      cmp_regs("R3 R4 value");
      @(negedge clk);
      chk("R5 one cycle", {28'd0, upd_strobe}, 32'd0);
    end

    // R2: a low-address store is not counted
    for (int b = 0; b < 4; b++) store(16'hA000, 1'b0, 1'b1);
    store(16'h4000, 1'b0, 1'b0);
    chk("R2 no commit", {28'd0, s_upd}, 32'd0);
    cmp_regs("R2 regs");
    store(16'hE000, 1'b0, 1'b0);
    model[3] = 5'h0F;
    chk("R2 commit fifth", {28'd0, s_upd}, 32'h8);
    cmp_regs("R2 R4 regs");

    // R7: reset with partial word pending
    load(2'd0, 5'h11); model[0] = 5'h11;
    for (int b = 0; b < 3; b++) store(16'hC000, 1'b0, 1'b1);
    store(16'h8000, 1'b1, 1'b0);
    model[0] = 5'h1D;
    chk("R7 cmd_reset", {31'd0, s_rst}, 32'd1);
    chk("R7 refresh", {29'd0, s_ref}, 32'd1);
    cmp_regs("R7 regs");
    @(negedge clk);
    chk("R7 pulse one cycle", {31'd0, cmd_reset}, 32'd0);

    // R8: guard window after reset
    store(16'hA000, 1'b0, 1'b1);
    tick(1);
    store(16'hA000, 1'b0, 1'b1);
    tick(1);
    store(16'hA000, 1'b0, 1'b1);
    for (int b = 0; b < 4; b++) store(16'hA000, 1'b0, 1'b0);
    model[1] = 5'h01;
    chk("R8 R7 commit", {28'd0, s_upd}, 32'h2);
    cmp_regs("R8 R7 guarded load");

    // R8: reset command inside the window is dropped
    tick(2);
    store(16'h8000, 1'b1, 1'b0);
    chk("R8 first reset", {31'd0, s_rst}, 32'd1);
    store(16'h8000, 1'b1, 1'b0);
    chk("R8 reset in window", {31'd0, s_rst}, 32'd0);

    // R9: long wait still opens the guard
    tick(5);
    store(16'h8000, 1'b1, 1'b0);
    chk("R9 saturate", {31'd0, s_rst}, 32'd1);
    tick(7);
    load(2'd2, 5'h15); model[2] = 5'h15;
    chk("R9 load after wait", {28'd0, s_upd}, 32'h4);
    cmp_regs("R9 regs");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule